// File: doc/BRIEF.md
# Packet-Mode Crossbar Matching Scheduler

This block decides, once per clock cycle (one switching slot), which inputs of an input-queued crossbar may send a cell to which outputs. Every input keeps one queue per output, and the block sees only a per-queue "has cells" flag plus the length, in cells, of the packet at the head of each queue. The block builds a conflict-free pairing of inputs and outputs in a fixed number of request/grant/accept rounds. Round-robin pointers break ties at each output and at each input.

On top of cell-by-cell matching, the block works in packet mode. When a pair is first matched for a packet of k cells, the block reserves that pair for the k-1 slots that follow. During those slots the pair's input and output take no part in arbitration. This keeps the cells of one packet back to back at the output, so cells of two packets never interleave there, and the output side needs no reassembly.

The transfer matrix is combinational from the current slot's inputs and the stored state: lock flags, lock counters and pointers. The stored state advances at the clock edge that closes the slot.

Top module: `pkt_xbar_sched`

## Requirements
- R1: In every slot each input appears in at most one matched pair, and each output appears in at most one matched pair. Bit i*N+j of the transfer matrix means input i sends to output j.
- R2: A pair that is not held by a lock is matched only when its occupancy bit (bit i*N+j of `voqOcc`) is 1. With all occupancy bits at 0 and no lock, the transfer matrix is 0.
- R3: An output that grants an input, with that grant accepted in the first round, next prefers the input one above it (modulo N). With all inputs contending for one output and one-cell packets, service rotates through inputs 0,1,2,...
- R4: An input that accepts an output in the first round next prefers the output one above it (modulo N). With one input requesting every output, it is served by outputs 0,1,2,... in turn.
- R5: Pointers move only on accepts made in the first round. A pair matched in a later round leaves its output's grant pointer and its input's accept pointer unchanged.
- R6: When a pair (i,j) is newly matched and the head packet length (field bits (i*N+j)*LEN_W upward of `holLen`) is k>=2, the pair is in the transfer matrix in each of the next k-1 slots, even when the occupancy bit is 0.
- R7: While a pair is held, its input's other occupancy bits are ignored, and no other input is matched to its output. Two held pairs never share an output.
- R8: A k-cell lock ends after k-1 held slots. In the following slot the input and output arbitrate normally again.
- R9: A head length of 1 or 0 creates no lock. The next slot is arbitrated normally.
- R10: After reset there are no locks and all pointers are 0. With every queue occupied and two rounds (N=4), the first slot matches (0,0) in round one and (1,1) in round two.
- R11: Later rounds extend the matching using only inputs and outputs left free by earlier rounds and by locks. Pairs already made are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voqOcc | input | N*N | Bit i*N+j: queue of input i for output j holds cells |
| holLen | input | N*N*LEN_W | Field i*N+j: cell count of the head packet of that queue |
| xferMatrix | output | N*N | Bit i*N+j: input i sends one cell to output j this slot |

## Verification
A single column of occupancy (all inputs wanting one output) isolates output-side rotation. A single row isolates input-side rotation. A full matrix run twice after reset shows the round count, and its second slot tells a design that moves pointers only on first-round accepts from one that also moves them in later rounds. A multi-cell packet, followed by a competitor on its output and stray requests from the locked input, shows that the hold is forced, how long it lasts and what it excludes. Lengths of 1 and 0 show that no hold is taken, and two concurrent holds of different lengths show independent release while the remaining ports keep matching.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;

  // Per-input report from the matching datapath to the lock control.
  typedef struct packed {
    logic matched;  // input owns a pair this slot
    logic fresh;    // that pair came from arbitration, not from a lock
  } matchEvt_t;

  function automatic int wrapInc(int idx, int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/pkt_rr_pick.sv
module pkt_rr_pick #(
  parameter int N = 4,
  parameter int PTR_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     reqVec,
  input  logic [PTR_W-1:0] startPtr,
  output logic [N-1:0]     pickOh
);

  always_comb begin
    logic found;
    int idx;
    pickOh = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(startPtr) + k) % N;
      if (!found && reqVec[idx]) begin
        pickOh[idx] = 1'b1;
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pkt_match_dp.sv
module pkt_match_dp
  import pkt_sched_pkg::*;
#(
  parameter int N = 4,
  parameter int ITER = 2,
  parameter int PTR_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N*N-1:0]        voqOcc,
  input  logic [N-1:0]          lockVld,
  input  logic [N*N-1:0]        lockMap,
  output logic [N*N-1:0]        xferMatrix,
  output matchEvt_t [N-1:0]     evt
);

  logic [N-1:0][PTR_W-1:0] grantPtr;
  logic [N-1:0][PTR_W-1:0] acceptPtr;

  logic [ITER:0][N*N-1:0] stMatch;
  logic [ITER:0][N-1:0]   stInBusy;
  logic [ITER:0][N-1:0]   stOutBusy;
  logic [N-1:0][N-1:0]    firstAcc;   // [input][output], round one only

  // Stage zero: held pairs are seated before any round.
  logic [N*N-1:0] seedMatch;
  logic [N-1:0]   seedIn;
  logic [N-1:0]   seedOut;

  always_comb begin
    seedMatch = '0;
    seedIn    = '0;
    seedOut   = '0;
    for (int i = 0; i < N; i++) begin
      if (lockVld[i]) begin
        for (int o = 0; o < N; o++) begin
          if (lockMap[i*N+o]) begin
            seedMatch[i*N+o] = 1'b1;
            seedIn[i]        = 1'b1;
            seedOut[o]       = 1'b1;
          end
        end
      end
    end
  end

  assign stMatch[0]   = seedMatch;
  assign stInBusy[0]  = seedIn;
  assign stOutBusy[0] = seedOut;

  for (genvar it = 0; it < ITER; it++) begin : g_iter
    logic [N-1:0][N-1:0] reqByOut;  // [output][input]
    logic [N-1:0][N-1:0] gntByOut;  // [output][input]
    logic [N-1:0][N-1:0] gntByIn;   // [input][output]
    logic [N-1:0][N-1:0] accByIn;   // [input][output]
    logic [N*N-1:0]      itMatch;
    logic [N-1:0]        itIn;
    logic [N-1:0]        itOut;

    always_comb begin
      for (int o = 0; o < N; o++) begin
        for (int i = 0; i < N; i++) begin
          reqByOut[o][i] = voqOcc[i*N+o] & ~stInBusy[it][i] & ~stOutBusy[it][o];
        end
      end
    end

    for (genvar p = 0; p < N; p++) begin : g_port
      pkt_rr_pick #(.N(N), .PTR_W(PTR_W)) u_gnt (
        .reqVec   (reqByOut[p]),
        .startPtr (grantPtr[p]),
        .pickOh   (gntByOut[p])
      );
      pkt_rr_pick #(.N(N), .PTR_W(PTR_W)) u_acc (
        .reqVec   (gntByIn[p]),
        .startPtr (acceptPtr[p]),
        .pickOh   (accByIn[p])
      );
    end

    always_comb begin
      for (int i = 0; i < N; i++) begin
        for (int o = 0; o < N; o++) begin
          gntByIn[i][o] = gntByOut[o][i];
        end
      end
    end

    always_comb begin
      itMatch = stMatch[it];
      itIn    = stInBusy[it];
      itOut   = stOutBusy[it];
      for (int i = 0; i < N; i++) begin
        for (int o = 0; o < N; o++) begin
          if (accByIn[i][o]) begin
            itMatch[i*N+o] = 1'b1;
            itIn[i]        = 1'b1;
            itOut[o]       = 1'b1;
          end
        end
      end
    end

    assign stMatch[it+1]   = itMatch;
    assign stInBusy[it+1]  = itIn;
    assign stOutBusy[it+1] = itOut;

    if (it == 0) begin : g_first
      assign firstAcc = accByIn;
    end
  end

  assign xferMatrix = stMatch[ITER];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      evt[i].matched = |xferMatrix[i*N +: N];
      evt[i].fresh   = |(xferMatrix[i*N +: N] & ~stMatch[0][i*N +: N]);
    end
  end

  // Pointers advance only on accepts of the first round.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grantPtr  <= '0;
      acceptPtr <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int o = 0; o < N; o++) begin
          if (firstAcc[i][o]) begin
            grantPtr[o]  <= PTR_W'(wrapInc(i, N));
            acceptPtr[i] <= PTR_W'(wrapInc(o, N));
          end
        end
      end
    end
  end

endmodule

// File: rtl/pkt_lock_ctrl.sv
module pkt_lock_ctrl
  import pkt_sched_pkg::*;
#(
  parameter int N = 4,
  parameter int LEN_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N*N*LEN_W-1:0] holLen,
  input  logic [N*N-1:0]       xferMatrix,
  input  matchEvt_t [N-1:0]    evt,
  output logic [N-1:0]         lockVld,
  output logic [N*N-1:0]       lockMap
);

  logic [N-1:0][LEN_W-1:0] lockRem;
  logic [N-1:0][LEN_W-1:0] selLen;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      selLen[i] = '0;
      for (int o = 0; o < N; o++) begin
        if (xferMatrix[i*N+o]) selLen[i] = selLen[i] | holLen[(i*N+o)*LEN_W +: LEN_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockVld <= '0;
      lockMap <= '0;
      lockRem <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (lockVld[i]) begin
          lockRem[i] <= lockRem[i] - LEN_W'(1);
          if (lockRem[i] <= LEN_W'(1)) begin
            lockVld[i]         <= 1'b0;
            lockMap[i*N +: N]  <= '0;
          end
        end else if (evt[i].matched && evt[i].fresh && (selLen[i] > LEN_W'(1))) begin
          lockVld[i]        <= 1'b1;
          lockMap[i*N +: N] <= xferMatrix[i*N +: N];
          lockRem[i]        <= selLen[i] - LEN_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pkt_xbar_sched.sv
module pkt_xbar_sched
  import pkt_sched_pkg::*;
#(
  parameter int N = 4,
  parameter int LEN_W = 4,
  parameter int ITER = (N > 2) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N*N-1:0]       voqOcc,
  input  logic [N*N*LEN_W-1:0] holLen,
  output logic [N*N-1:0]       xferMatrix
);

  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      lockVld;
  logic [N*N-1:0]    lockMap;
  matchEvt_t [N-1:0] evt;

  pkt_match_dp #(.N(N), .ITER(ITER), .PTR_W(PTR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .voqOcc     (voqOcc),
    .lockVld    (lockVld),
    .lockMap    (lockMap),
    .xferMatrix (xferMatrix),
    .evt        (evt)
  );

  pkt_lock_ctrl #(.N(N), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .holLen     (holLen),
    .xferMatrix (xferMatrix),
    .evt        (evt),
    .lockVld    (lockVld),
    .lockMap    (lockMap)
  );

endmodule

// File: rtl/pkt_xbar_sched_chk.sv
module pkt_xbar_sched_chk #(
  parameter int N = 4,
  parameter int LEN_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N*N-1:0]       voqOcc,
  input logic [N*N*LEN_W-1:0] holLen,
  input logic [N*N-1:0]       xferMatrix,
  input logic [N-1:0]         lockVld,
  input logic [N*N-1:0]       lockMap
);

  logic [N-1:0][N-1:0] colXfer;   // [output][input]
  logic [N-1:0][N-1:0] colLock;   // [output][input]

  always_comb begin
    for (int o = 0; o < N; o++) begin
      for (int i = 0; i < N; i++) begin
        colXfer[o][i] = xferMatrix[i*N+o];
        colLock[o][i] = lockMap[i*N+o] & lockVld[i];
      end
    end
  end

  for (genvar p = 0; p < N; p++) begin : g_one
    // R1
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xferMatrix[p*N +: N]));
    // R1
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(colXfer[p]));
    // R7
    lock_out_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(colLock[p]));
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    for (genvar o = 0; o < N; o++) begin : g_out
      // R2
      occ_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xferMatrix[i*N+o] && !lockVld[i]) |-> voqOcc[i*N+o]);
      // R6
      hold_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xferMatrix[i*N+o] && !lockVld[i] && (holLen[(i*N+o)*LEN_W +: LEN_W] > LEN_W'(1)))
          |=> xferMatrix[i*N+o]);
      // R7
      lock_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockVld[i] && lockMap[i*N+o]) |-> xferMatrix[i*N+o]);
    end
  end

endmodule

bind pkt_xbar_sched pkt_xbar_sched_chk #(.N(N), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .voqOcc     (voqOcc),
  .holLen     (holLen),
  .xferMatrix (xferMatrix),
  .lockVld    (lockVld),
  .lockMap    (lockMap)
);

// File: tb/pkt_xbar_sched_tb.sv
`timescale 1ns/1ps
module pkt_xbar_sched_tb;

  localparam int N = 4;
  localparam int LEN_W = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N*N-1:0]       voqOcc = '0;
  logic [N*N*LEN_W-1:0] holLen = '0;
  logic [N*N-1:0]       xferMatrix;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pkt_xbar_sched #(.N(N), .LEN_W(LEN_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .voqOcc     (voqOcc),
    .holLen     (holLen),
    .xferMatrix (xferMatrix)
  );

  task automatic setAllLen(input int v);
    for (int b = 0; b < N*N; b++) holLen[b*LEN_W +: LEN_W] = LEN_W'(v);
  endtask

  task automatic setLen(input int i, input int j, input int v);
    holLen[(i*N+j)*LEN_W +: LEN_W] = LEN_W'(v);
  endtask

  task automatic check(input string req, input logic [N*N-1:0] got, input logic [N*N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: xferMatrix=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive one slot at a falling edge, sample before the rising edge.
  task automatic slot(input logic [N*N-1:0] occ, input logic [N*N-1:0] exp, input string req);
    voqOcc = occ;
    #3;
    check(req, xferMatrix, exp);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n  = 1'b0;
    voqOcc = '0;
    setAllLen(1);
    @(negedge clk);
    #3;
    check("R10 reset", xferMatrix, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic testResetAndRounds();
    doReset();
    slot(16'h0000, 16'h0000, "R2 empty");
    doReset();
    slot(16'hFFFF, 16'h0021, "R10 R11 first slot");
    slot(16'hFFFF, 16'h0412, "R5 second slot");
  endtask

  task automatic testGrantRotate();
    doReset();
    for (int s = 0; s < 5; s++) begin
      logic [N*N-1:0] e;
      e = '0;
      e[(s % N) * N] = 1'b1;
      slot(16'h1111, e, "R3 grant rotation");
    end
  endtask

  task automatic testAcceptRotate();
    doReset();
    for (int s = 0; s < 5; s++) begin
      logic [N*N-1:0] e;
      e = '0;
      e[s % N] = 1'b1;
      slot(16'h000F, e, "R4 accept rotation");
    end
  endtask

  task automatic testPacketHold();
    doReset();
    setLen(0, 2, 3);
    slot(16'h0004, 16'h0004, "R6 first cell");
    setLen(0, 2, 1);
    slot(16'h0045, 16'h0004, "R7 hold excludes");
    slot(16'h0041, 16'h0004, "R6 hold without occupancy");
    slot(16'h0041, 16'h0041, "R8 release");
  endtask

  task automatic testNoLock();
    doReset();
    slot(16'h0004, 16'h0004, "R9 len1 first");
    slot(16'h0040, 16'h0040, "R9 len1 no hold");
    doReset();
    setLen(0, 2, 0);
    slot(16'h0004, 16'h0004, "R9 len0 first");
    slot(16'h0040, 16'h0040, "R9 len0 no hold");
  endtask

  task automatic testTwoLocks();
    doReset();
    setLen(0, 0, 2);
    setLen(1, 1, 4);
    slot(16'h0021, 16'h0021, "R1 two fresh pairs");
    setLen(0, 0, 1);
    setLen(1, 1, 1);
    slot(16'hFFFF, 16'h8421, "R7 R11 rounds around locks");
    slot(16'hFFFF, 16'h4128, "R8 independent release");
  endtask

  initial begin
    setAllLen(1);
    testResetAndRounds();
    testGrantRotate();
    testAcceptRotate();
    testPacketHold();
    testNoLock();
    testTwoLocks();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule